// File: doc/BRIEF.md
# Serial Sampling Converter Responder

This block stands in for a 12-bit serial sampling converter on the device side of a link. It is meant to be the partner of a host serial controller, either inside a testbench or in a hardware loopback. The host drives an active-low chip select and a serial clock. The responder answers on a serial data line that it can release, and it reports whether it is powered. The value it "converts" arrives on a parallel input and is captured at the moment of hold. No analog behaviour is modelled.

A falling chip select wakes the responder and puts it into track. A rising chip select captures the sample, turns on the data driver and presents the first of four leading zeros. Each later falling serial clock edge presents the next bit, with the sample sent MSB first. On the sixteenth falling edge the responder releases the line and powers down on its own.

Both host pins are synchronised into the system clock domain and edge-detected, so each pin edge takes effect three system clock cycles after it occurs. The host pins must toggle far more slowly than the system clock. The responder times the chip-select low phase and the spacing between chip-select falls in system clock cycles, and it flags a hold that comes too early and frames that come too fast. The sample input is a level that is read when hold occurs. It has no handshake and applies no back-pressure. Every flag is a single-cycle pulse.

Top module: `adcr_responder`

## Requirements
- R1: After a chip-select falling edge, `powered` is 1 and `sdata_oe` is 0 (track state).
- R2: A chip-select rising edge seen while tracking captures `sample`, sets `sdata_oe` to 1 and drives `sdata` to 0.
- R3: Each serial clock falling edge in a frame advances `sdata` by one bit. After the hold bit come three more zeros, then `sample[11]` down to `sample[0]`, so that the value after falling edge k (1..15) is bit 15-k of {4'b0000, sample}.
- R4: On the sixteenth serial clock falling edge of a frame, `sdata_oe` returns to 0 and `powered` returns to 0.
- R5: While powered down, serial clock edges change nothing: `sdata_oe` and `powered` stay 0, and the next frame is unaffected.
- R6: `acq_err` pulses for one cycle after hold exactly when chip select was low for fewer than ACQ_CYC system clock cycles. A low phase of ACQ_CYC cycles or more gives no pulse.
- R7: `rate_err` pulses for one cycle exactly when a chip-select fall comes fewer than RATE_CYC system clock cycles after the previous fall. The first fall after reset never flags.
- R8: A chip-select falling edge during a frame aborts it. `sdata_oe` drops to 0, `abort_err` pulses, the responder tracks again, and the next hold starts a new frame from the first leading zero.
- R9: Serial clock falling edges during track are ignored. The frame that follows still begins with its first leading zero.
- R10: In reset and right after it, `sdata_oe`, `powered`, `sdata` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sample | input | DATA_W | Value captured at hold |
| sdata | output | 1 | Serial data, valid when `sdata_oe` is 1 |
| sdata_oe | output | 1 | Output enable; 0 means high impedance |
| powered | output | 1 | 1 while tracking or shifting |
| acq_err | output | 1 | Pulse: chip-select low phase too short |
| rate_err | output | 1 | Pulse: chip-select falls too close together |
| abort_err | output | 1 | Pulse: frame aborted by chip-select fall |

## Verification
The bench sweeps a broad spread of sample values, including walking ones, all ones and zero. It checks every bit slot, so a responder that shifts one place early, drops a leading zero or sends the data LSB first shows a wrong bit in a known slot. It drives chip-select low phases and fall spacings of exactly threshold minus one and threshold. A comparison off by one cycle either misses the flag or raises it on a legal frame. It aborts a frame in its middle and toggles the serial clock while powered down and while tracking. A design that kept driving after an abort, or that counted stray clock edges, would resume at the wrong bit or would enable its output when it should not.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  typedef enum logic [1:0] {
    ST_PDOWN = 2'd0,
    ST_TRACK = 2'd1,
    ST_SHIFT = 2'd2
  } adcr_state_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/adcr_edge_sync.sv
module adcr_edge_sync #(
  parameter int unsigned N = 2,
  parameter logic [N-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  localparam int unsigned ST = adcr_pkg::SYNC_STAGES;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [ST-1:0] meta;
    logic          prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= {ST{IDLE[g]}};
        prev <= IDLE[g];
      end else begin
        meta <= {meta[ST-2:0], pin[g]};
        prev <= meta[ST-1];
      end
    end

    assign rise[g] = meta[ST-1] & ~prev;
    assign fall[g] = ~meta[ST-1] & prev;
  end
endmodule

// File: rtl/adcr_frame_timer.sv
module adcr_frame_timer #(
  parameter int unsigned ACQ_CYC  = 100,
  parameter int unsigned RATE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic in_track,
  output logic acq_viol,
  output logic rate_viol
);
  localparam int unsigned AW = $clog2(ACQ_CYC + 1);
  localparam int unsigned RW = $clog2(RATE_CYC + 1);
  localparam logic [AW-1:0] ACQ_LIM  = AW'(ACQ_CYC - 1);
  localparam logic [RW-1:0] RATE_LIM = RW'(RATE_CYC - 1);

  logic [AW-1:0] low_cnt;
  logic [RW-1:0] gap_cnt;
  logic          seen_fall;

  // low-phase length: cleared at the fall, counts each cycle spent tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      acq_viol <= 1'b0;
    end else begin
      acq_viol <= 1'b0;
      if (cs_fall) begin
        low_cnt <= '0;
      end else if (in_track) begin
        if (cs_rise) acq_viol <= (low_cnt < ACQ_LIM);
        if (low_cnt < ACQ_LIM) low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  // spacing between consecutive falls, saturating at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt   <= '0;
      seen_fall <= 1'b0;
      rate_viol <= 1'b0;
    end else begin
      rate_viol <= 1'b0;
      if (cs_fall) begin
        rate_viol <= seen_fall && (gap_cnt < RATE_LIM);
        gap_cnt   <= '0;
        seen_fall <= 1'b1;
      end else if (gap_cnt < RATE_LIM) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  a_r6_acq_follows_hold: assert property (@(posedge clk) disable iff (!rst_n)
    acq_viol |-> $past(cs_rise && in_track));
  a_r7_rate_follows_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rate_viol |-> $past(cs_fall));
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acq_viol, rate_viol}));
endmodule

// File: rtl/adcr_shift_out.sv
module adcr_shift_out #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              abort,
  input  logic [DATA_W-1:0] sample,
  output logic              sdata,
  output logic              oe,
  output logic              done
);
  localparam int unsigned LEAD = FRAME_W - DATA_W;
  localparam int unsigned CW   = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      cnt;

  assign done  = step && oe && !abort && !load && (cnt == LAST);
  assign sdata = oe & sh[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      oe  <= 1'b0;
    end else if (abort) begin
      oe <= 1'b0;
    end else if (load) begin
      sh  <= {{LEAD{1'b0}}, sample};
      cnt <= '0;
      oe  <= 1'b1;
    end else if (step && oe) begin
      if (cnt == LAST) begin
        oe <= 1'b0;
      end else begin
        sh  <= {sh[FRAME_W-2:0], 1'b0};
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r3_one_bit_per_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && oe && !abort && !load && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));
  a_r4_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !oe);
  a_r2_load_starts_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !abort) |=> (oe && !sdata && cnt == '0));
endmodule

// File: rtl/adcr_responder.sv
module adcr_responder #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned ACQ_CYC  = 100,
  parameter int unsigned RATE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              powered,
  output logic              acq_err,
  output logic              rate_err,
  output logic              abort_err
);
  import adcr_pkg::*;

  localparam int unsigned IDX_CS = 0;
  localparam int unsigned IDX_SK = 1;

  adcr_state_t state, state_nx;
  logic [1:0]  rise_v, fall_v;
  logic        cs_rise, cs_fall, sk_fall;
  logic        load, abort, done;

  adcr_edge_sync #(.N(2), .IDLE(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  ({sclk, cs_n}),
    .rise (rise_v),
    .fall (fall_v)
  );

  assign cs_rise = rise_v[IDX_CS];
  assign cs_fall = fall_v[IDX_CS];
  assign sk_fall = fall_v[IDX_SK];

  assign abort = cs_fall && (state == ST_SHIFT);
  assign load  = cs_rise && (state == ST_TRACK);

  always_comb begin
    state_nx = state;
    if (cs_fall)                        state_nx = ST_TRACK;
    else if (load)                      state_nx = ST_SHIFT;
    else if (state == ST_SHIFT && done) state_nx = ST_PDOWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PDOWN;
      abort_err <= 1'b0;
    end else begin
      state     <= state_nx;
      abort_err <= abort;
    end
  end

  assign powered = (state != ST_PDOWN);

  adcr_shift_out #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (sk_fall),
    .abort (abort),
    .sample(sample),
    .sdata (sdata),
    .oe    (sdata_oe),
    .done  (done)
  );

  adcr_frame_timer #(.ACQ_CYC(ACQ_CYC), .RATE_CYC(RATE_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .in_track (state == ST_TRACK),
    .acq_viol (acq_err),
    .rate_viol(rate_err)
  );

  a_r1_fall_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (state == ST_TRACK && !sdata_oe));
  a_r4_done_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cs_fall) |=> (state == ST_PDOWN));
  a_r5_drive_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> (state == ST_SHIFT));
  a_r8_abort_released: assert property (@(posedge clk) disable iff (!rst_n)
    abort_err |-> (!sdata_oe && state == ST_TRACK));
  a_r9_track_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRACK && !cs_rise) |=> !sdata_oe);
endmodule

// File: tb/adcr_responder_test.sv
module adcr_responder_test;
  localparam int ACQ  = 10;
  localparam int RATE = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] sample = '0;
  logic sdata, sdata_oe, powered, acq_err, rate_err, abort_err;

  int checks = 0, errors = 0;
  int n_acq = 0, n_rate = 0, n_abort = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adcr_responder #(.ACQ_CYC(ACQ), .RATE_CYC(RATE)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample),
    .sdata(sdata), .sdata_oe(sdata_oe), .powered(powered),
    .acq_err(acq_err), .rate_err(rate_err), .abort_err(abort_err)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (acq_err)   n_acq   <= n_acq + 1;
    if (rate_err)  n_rate  <= n_rate + 1;
    if (abort_err) n_abort <= n_abort + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sclk falling edges 1..16 after hold; verifies each bit and the release
  task automatic shift_frame(input logic [11:0] v);
    logic [15:0] w;
    w = {4'b0000, v};
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b0; tick(4);
      if (k < 16) begin
        check("R3 oe", int'(sdata_oe), 1);
        check("R3 bit", int'(sdata), int'(w[15-k]));
      end else begin
        check("R4 oe released", int'(sdata_oe), 0);
        check("R4 powered down", int'(powered), 0);
      end
      sclk = 1'b1; tick(4);
    end
  endtask

  task automatic hold_start(input int low);
    cs_n = 1'b0; tick(low);
    cs_n = 1'b1; tick(5);
    check("R2 oe on", int'(sdata_oe), 1);
    check("R2 first zero", int'(sdata), 0);
  endtask

  task automatic full_frame(input logic [11:0] v, input int gap);
    sample = v;
    hold_start(ACQ);
    shift_frame(v);
    tick(gap);
  endtask

  initial begin
    int a0, r0, b0, t0;
    tick(3);
    check("R10 oe", int'(sdata_oe), 0);
    check("R10 powered", int'(powered), 0);
    check("R10 sdata", int'(sdata), 0);
    check("R10 flags", int'({acq_err, rate_err, abort_err}), 0);
    rst_n = 1'b1; tick(3);
    check("R10 oe after", int'(sdata_oe), 0);
    check("R10 powered after", int'(powered), 0);

    // R5: sclk activity while powered down
    for (int i = 0; i < 5; i++) begin sclk = 1'b0; tick(3); sclk = 1'b1; tick(3); end
    check("R5 oe", int'(sdata_oe), 0);
    check("R5 powered", int'(powered), 0);

    // R1 track state
    sample = 12'hA5C;
    cs_n = 1'b0; tick(5);
    check("R1 powered", int'(powered), 1);
    check("R1 oe off", int'(sdata_oe), 0);
    // R9: sclk falls while tracking
    for (int i = 0; i < 3; i++) begin sclk = 1'b0; tick(4); sclk = 1'b1; tick(4); end
    check("R9 oe off", int'(sdata_oe), 0);
    cs_n = 1'b1; tick(5);
    check("R9 first zero", int'(sdata), 0);
    check("R2 oe on", int'(sdata_oe), 1);
    shift_frame(12'hA5C);
    tick(80);

    // R3 sweep: walking ones, extremes and a stride pattern
    a0 = n_acq; r0 = n_rate; b0 = n_abort;
    for (int i = 0; i < 12; i++) full_frame(12'(1 << i), 70);
    full_frame(12'hFFF, 70);
    full_frame(12'h000, 70);
    for (int k = 0; k < 240; k++) full_frame(12'((k * 17 + 3) % 4096), 70);
    check("R6 no acq on legal frames", n_acq - a0, 0);
    check("R7 no rate on spaced frames", n_rate - r0, 0);
    check("R8 no abort on full frames", n_abort - b0, 0);

    // R6 boundary
    a0 = n_acq; sample = 12'h3C1;
    hold_start(ACQ - 1); shift_frame(12'h3C1); tick(70);
    check("R6 short low flags", n_acq - a0, 1);
    a0 = n_acq;
    hold_start(ACQ); shift_frame(12'h3C1); tick(70);
    check("R6 exact low clean", n_acq - a0, 0);

    // R7 boundary: fall spacing RATE-1 then RATE
    r0 = n_rate; t0 = cyc; sample = 12'h5A5;
    hold_start(ACQ); shift_frame(12'h5A5);
    while (cyc - t0 < RATE - 1) @(negedge clk);
    t0 = cyc;
    hold_start(ACQ); shift_frame(12'h5A5);
    tick(2);
    check("R7 close falls flag", n_rate - r0, 1);
    r0 = n_rate;
    while (cyc - t0 < RATE) @(negedge clk);
    hold_start(ACQ); shift_frame(12'h5A5); tick(70);
    check("R7 exact spacing clean", n_rate - r0, 0);

    // R8 abort mid-frame
    b0 = n_abort; a0 = n_acq; sample = 12'h9E7;
    hold_start(ACQ);
    for (int i = 0; i < 5; i++) begin sclk = 1'b0; tick(4); sclk = 1'b1; tick(4); end
    cs_n = 1'b0; tick(5);
    check("R8 oe dropped", int'(sdata_oe), 0);
    check("R8 still powered", int'(powered), 1);
    check("R8 abort pulse", n_abort - b0, 1);
    tick(ACQ);
    sample = 12'h6B2;
    cs_n = 1'b1; tick(5);
    check("R8 restart zero", int'(sdata), 0);
    check("R8 restart oe", int'(sdata_oe), 1);
    shift_frame(12'h6B2);
    check("R8 no acq", n_acq - a0, 0);
    tick(20);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule